// File: doc/BRIEF.md
# Serial Text Response Sequencer

This block owns a single asynchronous serial output line and decides what goes out on it. While the attached execution unit is idle, every key scan code delivered by the keyboard receiver is translated to its ASCII character and echoed. When the execution unit finishes an instruction, it requests a response. The block then streams a fixed text message for that instruction out of a small message ROM, selected through a base address and a length. If allowed, it appends the instruction's numeric result as two decimal digits. It closes the line with a line feed and a carriage return, and then returns a one-cycle completion pulse.

A built-in 8N1 transmitter serialises each byte. The sequencer hands the transmitter a new byte only after the previous frame has fully left the line. Key strobes that arrive while a response is being printed are dropped.

Top module: `serial_text_sequencer`

## Requirements
- R1: After reset the serial line `txd` is high and `resp_done` is low.
- R2: Each byte is framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts `BIT_CYCLES` clocks, with a default of 10416.
- R3: A `key_valid` strobe while idle sends exactly one byte, the ASCII code of `key_code`. The mapping is: 0x1C→0x41, 0x32→0x42, 0x21→0x43, 0x23→0x44, 0x29→0x20, 0x45→0x30, 0x16→0x31, 0x1E→0x32, 0x26→0x33, 0x5A→0x0D.
- R4: A scan code outside that mapping is echoed as 0x3F.
- R5: An `exec_start` strobe while idle prints a message of bytes read from the ROM, where the ROM byte at address a is 0x41+a. The start address and byte count depend on `msg_sel`:
  - 0: start 0, 2 bytes
  - 1: start 2, 3 bytes
  - 2: start 5, 1 byte
  - 3: start 6, 4 bytes
- R6: With `show_num` high at the request, the message is followed by the tens digit and then the units digit of `result`, each plus 0x30. A leading zero is kept.
- R7: A `result` above 99 is printed as 99.
- R8: With `show_num` low, no digits are sent.
- R9: Every response ends with 0x0A followed by 0x0D. `resp_done` is then high for exactly one cycle, after the last stop bit has been completed.
- R10: `key_valid` strobes during a response send nothing.
- R11: When `exec_start` and `key_valid` arrive in the same cycle, the response is served and the key is dropped.
- R12: A new byte is loaded into the transmitter only while it is not busy, and every frame starts with the line going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | One-cycle strobe: a new scan code is available |
| key_code | input | 8 | Scan code from the keyboard receiver |
| exec_start | input | 1 | One-cycle strobe: print the response for a finished instruction |
| msg_sel | input | 2 | Selects which message to print |
| show_num | input | 1 | Append the numeric result to the response |
| result | input | 7 | Binary result to print |
| txd | output | 1 | Serial output line |
| resp_done | output | 1 | One-cycle pulse when the response has been fully sent |

## Verification
The checks capture bytes at bit centres and compare them against a queue of expected characters.

Echo is tried with mapped letters, mapped digits and an unmapped code; this separates table lookup from the fallback character. A space character is also sent, and its long low run pins down the bit width and the bit order. Responses cover all four message selections, with and without digits, with a single-digit value, and with a value above 99. These distinguish start/length decoding, digit order, leading zeros and clamping. Keys pressed during a response, and a key arriving together with a request, show whether the arbitration is correct: any extra byte lands in the queue as a mismatch.

// File: rtl/txr_pkg.sv
// Package: shared types and lookup functions for the serial text sequencer.
// Assumes a 2-bit message selector and a 7-bit result.
package txr_pkg;

    localparam int BYTE_W = 8;
    localparam int RES_W  = 7;
    localparam int SEL_W  = 2;
    localparam int ROM_AW = 4;

    // Top-level sequencing state
    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_DONE} seq_st_t;

    // Which part of the output is being produced
    typedef enum logic [2:0] {P_ECHO, P_MSG, P_NUM, P_LF, P_CR} seq_ph_t;

    // Scan code to ASCII for the supported keys; anything else maps to '?'
    function automatic logic [BYTE_W-1:0] scan_to_ascii(input logic [BYTE_W-1:0] sc);
        case (sc)
            8'h1C:   return 8'h41;
            8'h32:   return 8'h42;
            8'h21:   return 8'h43;
            8'h23:   return 8'h44;
            8'h29:   return 8'h20;
            8'h45:   return 8'h30;
            8'h16:   return 8'h31;
            8'h1E:   return 8'h32;
            8'h26:   return 8'h33;
            8'h5A:   return 8'h0D;
            default: return 8'h3F;
        endcase
    endfunction

    // Start address of each message in the ROM
    function automatic logic [ROM_AW-1:0] msg_base(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    return 4'd0;
            2'd1:    return 4'd2;
            2'd2:    return 4'd5;
            default: return 4'd6;
        endcase
    endfunction

    // Byte count of each message (never zero)
    function automatic logic [ROM_AW-1:0] msg_len(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    return 4'd2;
            2'd1:    return 4'd3;
            2'd2:    return 4'd1;
            default: return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/txr_msg_rom.sv
// Message ROM: returns the text byte stored at an address.
// Content is computed (letter sequence from 'A') rather than listed.
module txr_msg_rom
    import txr_pkg::*;
(
    input  logic [ROM_AW-1:0] addr,
    output logic [BYTE_W-1:0] data
);
    // Purpose: compute the byte at the requested address
    always_comb data = 8'h41 + {{(BYTE_W-ROM_AW){1'b0}}, addr};
endmodule

// File: rtl/txr_bin2dec.sv
// Binary to two-digit ASCII converter.
// Assumes the input is unsigned; values above 99 saturate to 99.
module txr_bin2dec
    import txr_pkg::*;
(
    input  logic [RES_W-1:0]    value,
    output logic [2*BYTE_W-1:0] digits
);
    logic [RES_W-1:0] clamped;
    logic [3:0]       tens;
    logic [3:0]       units;

    // Purpose: clamp, then split into tens and units and add the ASCII offset
    always_comb begin
        clamped = (value > 7'd99) ? 7'd99 : value;
        tens    = 4'(clamped / 7'd10);
        units   = 4'(clamped - 7'(tens) * 7'd10);
        digits  = {4'h3, tens, 4'h3, units};
    end
endmodule

// File: rtl/txr_uart_tx.sv
// 8N1 serial transmitter, least significant bit first.
// Assumes load is asserted only while busy is low.
module txr_uart_tx #(
    parameter int BIT_CYCLES = 10416
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    output logic       txd,
    output logic       busy
);
    localparam int CNT_W   = $clog2(BIT_CYCLES + 1);
    localparam int FRAME_N = 10;

    logic [FRAME_N-1:0] shreg;
    logic [CNT_W-1:0]   baud_cnt;
    logic [3:0]         bit_idx;

    // Purpose: load a frame, time each bit and shift the frame out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '1;
            baud_cnt <= '0;
            bit_idx  <= '0;
            busy     <= 1'b0;
        end else if (!busy) begin
            if (load) begin
                shreg    <= {1'b1, data, 1'b0};
                baud_cnt <= '0;
                bit_idx  <= '0;
                busy     <= 1'b1;
            end
        end else if (baud_cnt == CNT_W'(BIT_CYCLES - 1)) begin
            baud_cnt <= '0;
            shreg    <= {1'b1, shreg[FRAME_N-1:1]};
            bit_idx  <= bit_idx + 4'd1;
            if (bit_idx == 4'(FRAME_N - 1))
                busy <= 1'b0;
        end else begin
            baud_cnt <= baud_cnt + 1'b1;
        end
    end

    // Purpose: line is high when idle, otherwise the current frame bit
    always_comb txd = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/serial_text_sequencer.sv
// Serial text response sequencer.
// Echoes keys while idle and prints instruction responses (message, optional
// two-digit result, LF, CR) followed by a one-cycle completion pulse.
// Assumes key_valid and exec_start are single-cycle strobes.
module serial_text_sequencer
    import txr_pkg::*;
#(
    parameter int BIT_CYCLES = 10416
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_valid,
    input  logic [7:0]       key_code,
    input  logic             exec_start,
    input  logic [1:0]       msg_sel,
    input  logic             show_num,
    input  logic [6:0]       result,
    output logic             txd,
    output logic             resp_done
);
    seq_st_t            st;
    seq_ph_t            ph;
    logic [ROM_AW-1:0]  cnt;
    logic [BYTE_W-1:0]  key_q;
    logic [SEL_W-1:0]   sel_q;
    logic               show_q;
    logic [2*BYTE_W-1:0] num_q;
    logic [2*BYTE_W-1:0] num_ascii;
    logic [ROM_AW-1:0]  rom_addr;
    logic [BYTE_W-1:0]  rom_data;
    logic [BYTE_W-1:0]  tx_byte;
    logic               tx_load;
    logic               tx_busy;

    txr_bin2dec u_b2d (.value(result), .digits(num_ascii));
    txr_msg_rom u_rom (.addr(rom_addr), .data(rom_data));
    txr_uart_tx #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .data(tx_byte),
        .txd(txd), .busy(tx_busy)
    );

    // Purpose: pick the byte for the current phase
    always_comb begin
        rom_addr = msg_base(sel_q) + cnt;
        case (ph)
            P_ECHO:  tx_byte = scan_to_ascii(key_q);
            P_MSG:   tx_byte = rom_data;
            P_NUM:   tx_byte = num_q[2*BYTE_W-1:BYTE_W];
            P_LF:    tx_byte = 8'h0A;
            default: tx_byte = 8'h0D;
        endcase
        tx_load = (st == S_LOAD);
    end

    // Purpose: sequence the phases and wait for each frame to finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            ph        <= P_ECHO;
            cnt       <= '0;
            key_q     <= '0;
            sel_q     <= '0;
            show_q    <= 1'b0;
            num_q     <= '0;
            resp_done <= 1'b0;
        end else begin
            resp_done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (exec_start) begin
                        sel_q  <= msg_sel;
                        show_q <= show_num;
                        num_q  <= num_ascii;
                        cnt    <= '0;
                        ph     <= P_MSG;
                        st     <= S_LOAD;
                    end else if (key_valid) begin
                        key_q <= key_code;
                        ph    <= P_ECHO;
                        st    <= S_LOAD;
                    end
                end
                S_LOAD: st <= S_WAIT;
                S_WAIT: begin
                    if (!tx_busy) begin
                        st <= S_LOAD;
                        case (ph)
                            P_ECHO: st <= S_IDLE;
                            P_MSG: begin
                                if (cnt == msg_len(sel_q) - 4'd1) begin
                                    cnt <= '0;
                                    ph  <= show_q ? P_NUM : P_LF;
                                end else begin
                                    cnt <= cnt + 4'd1;
                                end
                            end
                            P_NUM: begin
                                num_q <= {num_q[BYTE_W-1:0], {BYTE_W{1'b0}}};
                                if (cnt == 4'd1) ph <= P_LF;
                                else cnt <= cnt + 4'd1;
                            end
                            P_LF:    ph <= P_CR;
                            default: st <= S_DONE;
                        endcase
                    end
                end
                default: begin
                    resp_done <= 1'b1;
                    st        <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/txr_checker.sv
// Checker for the serial text sequencer: protocol properties between the
// sequencer and its transmitter. Attached with bind below.
module txr_checker (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic tx_busy,
    input logic tx_load,
    input logic resp_done
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
    a_r12_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> !tx_busy);
    a_r12_frame_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);
    a_r9_done_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> (!tx_busy && txd));
endmodule

bind serial_text_sequencer txr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
    .tx_load(tx_load), .resp_done(resp_done)
);

// File: tb/sim_serial_text_sequencer.sv
// Scoreboard bench: drivers push expected bytes, a line monitor decodes
// frames and compares them in order.
module sim_serial_text_sequencer;
    localparam int BIT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [7:0] key_code = '0;
    logic       exec_start = 1'b0;
    logic [1:0] msg_sel = '0;
    logic       show_num = 1'b0;
    logic [6:0] result = '0;
    logic       txd;
    logic       resp_done;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    serial_text_sequencer #(.BIT_CYCLES(BIT)) u0 (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .exec_start(exec_start), .msg_sel(msg_sel), .show_num(show_num),
        .result(result), .txd(txd), .resp_done(resp_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endtask

    // Monitor: decode frames at bit centres and compare with the queue
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                repeat (BIT/2 - 1) @(negedge clk);
                chk(txd == 1'b0, "R2 start", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT) @(negedge clk);
                    b[i] = txd;
                end
                repeat (BIT) @(negedge clk);
                chk(txd == 1'b1, "R2 stop", txd, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected byte", b, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(b == e, t, b, e);
                end
            end
        end
    end

    task automatic echo(input logic [7:0] sc, input logic [7:0] asc, input string req);
        push(asc, req);
        @(negedge clk);
        key_valid = 1'b1;
        key_code  = sc;
        @(negedge clk);
        key_valid = 1'b0;
        repeat (12*BIT) @(negedge clk);
    endtask

    task automatic respond(input logic [1:0] sel, input bit show, input logic [6:0] val,
                           input bit key_mid, input bit key_same);
        int base, len, v, n;
        base = (sel == 0) ? 0 : (sel == 1) ? 2 : (sel == 2) ? 5 : 6;
        len  = (sel == 0) ? 2 : (sel == 1) ? 3 : (sel == 2) ? 1 : 4;
        for (int i = 0; i < len; i++) push(8'(8'h41 + base + i), "R5 message");
        if (show) begin
            v = (val > 99) ? 99 : int'(val);
            push(8'(8'h30 + v/10), (val > 99) ? "R7 tens" : "R6 tens");
            push(8'(8'h30 + v%10), (val > 99) ? "R7 units" : "R6 units");
        end
        push(8'h0A, "R9 lf");
        push(8'h0D, "R9 cr");
        @(negedge clk);
        exec_start = 1'b1;
        msg_sel    = sel;
        show_num   = show;
        result     = val;
        if (key_same) begin key_valid = 1'b1; key_code = 8'h1C; end
        @(negedge clk);
        exec_start = 1'b0;
        key_valid  = 1'b0;
        if (key_mid) begin
            repeat (3*BIT) @(negedge clk);
            key_valid = 1'b1;
            key_code  = 8'h32;
            @(negedge clk);
            key_valid = 1'b0;
        end
        n = 0;
        while (!resp_done && n < 200*BIT) begin
            @(negedge clk);
            n++;
        end
        chk(resp_done == 1'b1, "R9 done seen", resp_done, 1);
        chk(exp_q.size() == 0, "R9 done after last byte", exp_q.size(), 0);
        @(negedge clk);
        chk(resp_done == 1'b0, "R9 done one cycle", resp_done, 0);
        repeat (12*BIT) @(negedge clk);
        chk(exp_q.size() == 0, key_same ? "R11 key dropped" : "R10 queue drained",
            exp_q.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lowrun;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(resp_done == 1'b0, "R1 done low", resp_done, 0);

        echo(8'h1C, 8'h41, "R3 key A");
        echo(8'h45, 8'h30, "R3 key 0");
        echo(8'h77, 8'h3F, "R4 unmapped");

        // R2: space (0x20) gives start + five low data bits = 6 bit times low
        push(8'h20, "R3 space");
        @(negedge clk);
        key_valid = 1'b1;
        key_code  = 8'h29;
        @(negedge clk);
        key_valid = 1'b0;
        while (txd) @(negedge clk);
        lowrun = 0;
        while (!txd) begin
            lowrun++;
            @(negedge clk);
        end
        chk(lowrun == 6*BIT, "R2 bit timing lsb first", lowrun, 6*BIT);
        repeat (8*BIT) @(negedge clk);

        respond(2'd0, 1'b1, 7'd42,  1'b0, 1'b0);
        respond(2'd1, 1'b0, 7'd42,  1'b0, 1'b0);  // R8
        respond(2'd2, 1'b1, 7'd7,   1'b0, 1'b0);  // R6 leading zero
        respond(2'd3, 1'b1, 7'd120, 1'b1, 1'b0);  // R7 and R10
        respond(2'd2, 1'b0, 7'd0,   1'b0, 1'b1);  // R11
        chk(txd == 1'b1, "R1 idle after all", txd, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule